// File: doc/BRIEF.md
# Vector Element Step Sequencer

This block drives the element and subvector indices of a vector loop. A start pulse captures a loop configuration: vector length, subvector length, one nesting-order flag per side, a vertical-first flag and a parallelism hint. The block then walks every (element, subelement) pair of the loop. For each group it presents the source and destination element index, the source and destination subvector index, and the number of pairs the group covers.

The source side and the destination side each have their own nesting order, so one side can run subvector-major while the other runs element-major. In horizontal mode the walk moves forward on its own every cycle. In vertical-first mode it moves only when an explicit step strobe arrives. A nonzero hint fixes the size of every step in that mode. The last group is clipped to what remains. A subvector length outside 1..4 is refused with an error pulse. A zero-length loop completes at once.

Internally a single linear pair position is kept. Each side maps that position to its (element, subelement) pair according to its own ordering.

Top module: `vstep_seq`

## Requirements
- R1: After reset, busy, done and subvl_err are 0, all four indices are 0 and issue_pairs is 0. The same outputs apply whenever the block is idle.
- R2: A start with cfg_subvl of 0, 5, 6 or 7 raises subvl_err for exactly the one cycle after the start edge. busy stays 0 and done stays 0.
- R3: In the default order the element index is the outer loop and the subvector index the inner one. For VL=5, SUBVL=3 the first pairs are (0,0),(0,1),(0,2),(1,0). Indices stay below VL and SUBVL.
- R4: cfg_pack=1 makes the source side subvector-major. Its pairs run (0,0),(1,0),...,(VL-1,0),(0,1) and so on. The destination side is unaffected.
- R5: cfg_unpack=1 makes the destination side subvector-major in the same way, independently of cfg_pack.
- R6: With cfg_vfirst=0 the position moves forward by min(HF_LANES, remaining) pairs on every busy cycle, and issue_pairs reports that count. The default HF_LANES is 1. The adv input has no effect in this mode.
- R7: With cfg_vfirst=1 the indices hold for as long as adv is 0. With a zero hint, each cycle with adv=1 moves forward by one pair.
- R8: With cfg_vfirst=1 and a hint H>0, every adv moves forward by H*SUBVL pairs, and issue_pairs shows H*SUBVL before the step.
- R9: When fewer pairs remain than the step size, issue_pairs and the final step are clipped to the remaining count.
- R10: With cfg_vfirst=1 and hint equal to VL, one step covers all VL*SUBVL pairs.
- R11: In the cycle after the final step, done is 1 for one cycle, busy is 0 and the indices are 0.
- R12: A start with a legal SUBVL and VL=0 gives a one-cycle done pulse in the next cycle. busy never rises.
- R13: A cfg_vl above MAXVL (64) is truncated to MAXVL.
- R14: A start while busy is ignored. The walk continues unchanged and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture configuration and begin a loop (ignored while busy) |
| adv | input | 1 | Explicit step request, used in vertical-first mode only |
| cfg_vl | input | 7 | Vector length, 0..127, truncated to MAXVL |
| cfg_subvl | input | 3 | Subvector length, legal 1..4 |
| cfg_pack | input | 1 | Source side subvector-major when 1 |
| cfg_unpack | input | 1 | Destination side subvector-major when 1 |
| cfg_vfirst | input | 1 | Vertical-first mode: step only on adv |
| cfg_hint | input | 7 | Elements per step in vertical-first mode, 0 = none |
| busy | output | 1 | Loop in progress |
| srcstep | output | 7 | Source element index of the current group |
| ssubstep | output | 2 | Source subvector index of the current group |
| dststep | output | 7 | Destination element index of the current group |
| dsubstep | output | 2 | Destination subvector index of the current group |
| issue_pairs | output | 9 | Pairs covered by the current group |
| done | output | 1 | One-cycle completion pulse |
| subvl_err | output | 1 | One-cycle pulse for an illegal subvector length |

## Verification
The hardest case to reach is a start that arrives while a walk is already running and carries a configuration that would otherwise be refused or would restart the loop. The horizontal-mode scenario raises start with an illegal SUBVL and a new VL in the middle of a walk. It then confirms that every later pair still follows the original sequence and that no error pulse appears. A similar difficulty holds for the clipped last group in vertical-first mode: the bench picks VL values that are not multiples of the hint, so the final step is shorter than the others.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  localparam int SUBVL_W   = 3;
  localparam int SUBVL_MAX = 4;
  localparam int SUBIDX_W  = 2;

  // Subvector lengths 1..SUBVL_MAX are accepted
  function automatic logic subvl_ok(input logic [SUBVL_W-1:0] s);
    return (s != '0) && (int'(s) <= SUBVL_MAX);
  endfunction

endpackage

// File: rtl/vstep_cfg.sv
module vstep_cfg
  import vstep_pkg::*;
#(
  parameter int MAXVL    = 64,
  parameter int EW       = 7,
  parameter int PW       = 9,
  parameter int HF_LANES = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [EW-1:0]      vl,
  input  logic [SUBVL_W-1:0] subvl,
  input  logic               pack,
  input  logic               unpack,
  input  logic               vfirst,
  input  logic [EW-1:0]      hint,
  output logic [EW-1:0]      vl_q,
  output logic [SUBVL_W-1:0] subvl_q,
  output logic               pack_q,
  output logic               unpack_q,
  output logic [PW-1:0]      total,
  output logic [PW-1:0]      step,
  output logic               vfirst_q,
  output logic               launch,
  output logic               launch_empty,
  output logic               err_q
);

  localparam logic [EW-1:0] VL_CAP = EW'(MAXVL);

  logic [EW-1:0] vl_eff;
  logic [EW-1:0] hint_eff;
  logic [EW-1:0] hint_q;
  logic          legal;

  function automatic logic [EW-1:0] clip_vl(input logic [EW-1:0] v);
    return (v > VL_CAP) ? VL_CAP : v;
  endfunction

  function automatic logic [PW-1:0] step_of(input logic vf, input logic [EW-1:0] h,
                                            input logic [SUBVL_W-1:0] s);
    if (!vf)        return PW'(HF_LANES);
    else if (h == '0) return PW'(1);
    else            return PW'(h) * PW'(s);
  endfunction

  assign vl_eff       = clip_vl(vl);
  assign hint_eff     = (hint > vl_eff) ? vl_eff : hint;
  assign legal        = subvl_ok(subvl);
  assign launch       = accept && legal && (vl_eff != '0);
  assign launch_empty = accept && legal && (vl_eff == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q     <= '0;
      subvl_q  <= '0;
      pack_q   <= 1'b0;
      unpack_q <= 1'b0;
      vfirst_q <= 1'b0;
      hint_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      if (launch) begin
        vl_q     <= vl_eff;
        subvl_q  <= subvl;
        pack_q   <= pack;
        unpack_q <= unpack;
        vfirst_q <= vfirst;
        hint_q   <= hint_eff;
      end
    end
  end

  assign total = PW'(vl_q) * PW'(subvl_q);
  assign step  = step_of(vfirst_q, hint_q, subvl_q);

  // R13
  vl_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (vl_q <= VL_CAP) && (vl_q != '0));

  // R2
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !$past(launch) && !$past(launch_empty));

endmodule

// File: rtl/vstep_count.sv
module vstep_count #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_empty,
  input  logic          advance,
  input  logic [PW-1:0] total,
  input  logic [PW-1:0] step,
  output logic          busy,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] cnt,
  output logic          fin
);

  logic [PW-1:0] rem;
  logic          move;
  logic          wrap;

  function automatic logic [PW-1:0] clip_step(input logic [PW-1:0] s, input logic [PW-1:0] r);
    return (s < r) ? s : r;
  endfunction

  assign rem  = total - pos;
  assign cnt  = busy ? clip_step(step, rem) : '0;
  assign move = busy && advance;
  assign wrap = move && (cnt == rem);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= launch_empty || wrap;
      if (launch) begin
        busy <= 1'b1;
        pos  <= '0;
      end else if (wrap) begin
        busy <= 1'b0;
        pos  <= '0;
      end else if (move) begin
        pos <= pos + cnt;
      end
    end
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pos < total));

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !advance) |=> busy && $stable(pos));

  // R8
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !wrap) |=> (pos == $past(pos) + $past(cnt)));

  // R11
  wrap_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> fin && !busy && (pos == '0));

  // R9
  cnt_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0) && (cnt <= rem));

endmodule

// File: rtl/vstep_map.sv
module vstep_map
  import vstep_pkg::*;
#(
  parameter int EW = 7,
  parameter int PW = 9
) (
  input  logic [PW-1:0]       pos,
  input  logic [EW-1:0]       vl,
  input  logic [SUBVL_W-1:0]  subvl,
  input  logic                sub_major,
  output logic [EW-1:0]       elem,
  output logic [SUBIDX_W-1:0] sub
);

  // element index when subvector is the inner loop
  function automatic logic [PW-1:0] elem_major(input logic [PW-1:0] p,
                                               input logic [SUBVL_W-1:0] n);
    case (n)
      3'd2:    return p >> 1;
      3'd3:    return p / PW'(3);
      3'd4:    return p >> 2;
      default: return p;
    endcase
  endfunction

  // how many whole element sweeps lie below position p
  function automatic logic [SUBIDX_W-1:0] sweep_of(input logic [PW-1:0] p,
                                                   input logic [PW-1:0] v);
    logic [PW-1:0] v2;
    logic [PW-1:0] v3;
    v2 = v << 1;
    v3 = v2 + v;
    if (v == '0)   return '0;
    if (p >= v3)   return 2'd3;
    if (p >= v2)   return 2'd2;
    if (p >= v)    return 2'd1;
    return 2'd0;
  endfunction

  always_comb begin
    if (sub_major) begin
      sub  = sweep_of(pos, PW'(vl));
      elem = EW'(pos - PW'(sweep_of(pos, PW'(vl))) * PW'(vl));
    end else begin
      elem = EW'(elem_major(pos, subvl));
      sub  = SUBIDX_W'(pos - elem_major(pos, subvl) * PW'(subvl));
    end
  end

endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
  import vstep_pkg::*;
#(
  parameter int MAXVL    = 64,
  parameter int HF_LANES = 1,
  localparam int EW      = $clog2(MAXVL + 1),
  localparam int PW      = $clog2(MAXVL * SUBVL_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                adv,
  input  logic [EW-1:0]       cfg_vl,
  input  logic [SUBVL_W-1:0]  cfg_subvl,
  input  logic                cfg_pack,
  input  logic                cfg_unpack,
  input  logic                cfg_vfirst,
  input  logic [EW-1:0]       cfg_hint,
  output logic                busy,
  output logic [EW-1:0]       srcstep,
  output logic [SUBIDX_W-1:0] ssubstep,
  output logic [EW-1:0]       dststep,
  output logic [SUBIDX_W-1:0] dsubstep,
  output logic [PW-1:0]       issue_pairs,
  output logic                done,
  output logic                subvl_err
);

  logic                accept;
  logic                advance;
  logic [EW-1:0]       vl_q;
  logic [SUBVL_W-1:0]  subvl_q;
  logic                pack_q;
  logic                unpack_q;
  logic                vfirst_q;
  logic [PW-1:0]       total;
  logic [PW-1:0]       step;
  logic                launch;
  logic                launch_empty;
  logic [PW-1:0]       pos;
  logic [PW-1:0]       cnt;
  logic [1:0]          side_major;
  logic [EW-1:0]       side_elem [2];
  logic [SUBIDX_W-1:0] side_sub  [2];

  assign accept  = start && !busy;
  assign advance = vfirst_q ? adv : 1'b1;

  vstep_cfg #(.MAXVL(MAXVL), .EW(EW), .PW(PW), .HF_LANES(HF_LANES)) u_cfg (
    .clk, .rst_n, .accept,
    .vl(cfg_vl), .subvl(cfg_subvl), .pack(cfg_pack), .unpack(cfg_unpack),
    .vfirst(cfg_vfirst), .hint(cfg_hint),
    .vl_q, .subvl_q, .pack_q, .unpack_q, .total, .step, .vfirst_q,
    .launch, .launch_empty, .err_q(subvl_err)
  );

  vstep_count #(.PW(PW)) u_count (
    .clk, .rst_n, .launch, .launch_empty, .advance, .total, .step,
    .busy, .pos, .cnt, .fin(done)
  );

  assign side_major = {unpack_q, pack_q};

  // side 0 = source, side 1 = destination
  for (genvar g = 0; g < 2; g++) begin : g_side
    vstep_map #(.EW(EW), .PW(PW)) u_map (
      .pos, .vl(vl_q), .subvl(subvl_q), .sub_major(side_major[g]),
      .elem(side_elem[g]), .sub(side_sub[g])
    );
  end

  assign srcstep     = busy ? side_elem[0] : '0;
  assign ssubstep    = busy ? side_sub[0]  : '0;
  assign dststep     = busy ? side_elem[1] : '0;
  assign dsubstep    = busy ? side_sub[1]  : '0;
  assign issue_pairs = cnt;

  // R3
  src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (srcstep < vl_q) && (SUBVL_W'(ssubstep) < subvl_q));

  // R3
  dst_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dststep < vl_q) && (SUBVL_W'(dsubstep) < subvl_q));

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subvl_err |-> !busy && !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (srcstep == '0) && (dststep == '0) && (issue_pairs == '0));

  // R7
  vf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vfirst_q && !adv) |=> $stable(srcstep) && $stable(dststep)
                                    && $stable(ssubstep) && $stable(dsubstep));

  // R14
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !subvl_err);

endmodule

// File: tb/vstep_seq_tb.sv
module vstep_seq_tb;

  localparam int MAXVL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       adv = 1'b0;
  logic [6:0] cfg_vl = '0;
  logic [2:0] cfg_subvl = '0;
  logic       cfg_pack = 1'b0;
  logic       cfg_unpack = 1'b0;
  logic       cfg_vfirst = 1'b0;
  logic [6:0] cfg_hint = '0;
  logic       busy;
  logic [6:0] srcstep;
  logic [1:0] ssubstep;
  logic [6:0] dststep;
  logic [1:0] dsubstep;
  logic [8:0] issue_pairs;
  logic       done;
  logic       subvl_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int e_src [256];
  int s_src [256];
  int e_dst [256];
  int s_dst [256];

  always #2 clk = ~clk;

  vstep_seq u_dut (
    .clk, .rst_n, .start, .adv, .cfg_vl, .cfg_subvl, .cfg_pack, .cfg_unpack,
    .cfg_vfirst, .cfg_hint, .busy, .srcstep, .ssubstep, .dststep, .dsubstep,
    .issue_pairs, .done, .subvl_err
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected pair order, written as nested loops per side
  task automatic build(int vl, int sv, bit pk, bit up);
    int k;
    k = 0;
    if (!pk) begin
      for (int e = 0; e < vl; e++) for (int s = 0; s < sv; s++) begin
        e_src[k] = e; s_src[k] = s; k++;
      end
    end else begin
      for (int s = 0; s < sv; s++) for (int e = 0; e < vl; e++) begin
        e_src[k] = e; s_src[k] = s; k++;
      end
    end
    k = 0;
    if (!up) begin
      for (int e = 0; e < vl; e++) for (int s = 0; s < sv; s++) begin
        e_dst[k] = e; s_dst[k] = s; k++;
      end
    end else begin
      for (int s = 0; s < sv; s++) for (int e = 0; e < vl; e++) begin
        e_dst[k] = e; s_dst[k] = s; k++;
      end
    end
  endtask

  task automatic kick(int vl, int sv, bit pk, bit up, bit vf, int hint);
    @(negedge clk);
    cfg_vl = 7'(vl); cfg_subvl = 3'(sv); cfg_pack = pk; cfg_unpack = up;
    cfg_vfirst = vf; cfg_hint = 7'(hint); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_pair(string tag, int p);
    check({tag, " srcstep"},  int'(srcstep),  e_src[p]);
    check({tag, " ssubstep"}, int'(ssubstep), s_src[p]);
    check({tag, " dststep"},  int'(dststep),  e_dst[p]);
    check({tag, " dsubstep"}, int'(dsubstep), s_dst[p]);
  endtask

  task automatic check_finish();
    check("R11 done pulse", int'(done), 1);
    check("R11 busy low", int'(busy), 0);
    check("R11 srcstep zero", int'(srcstep), 0);
    check("R11 dststep zero", int'(dststep), 0);
    @(negedge clk);
    check("R11 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 subvl_err", int'(subvl_err), 0);
    check("R1 srcstep", int'(srcstep), 0);
    check("R1 dsubstep", int'(dsubstep), 0);
    check("R1 issue_pairs", int'(issue_pairs), 0);
  endtask

  // horizontal walk; adv level and a mid-walk start are optional disturbances
  task automatic t_horiz(int vl, int sv, bit pk, bit up, bit adv_lvl, bit poke);
    int veff;
    veff = (vl > MAXVL) ? MAXVL : vl;
    build(veff, sv, pk, up);
    adv = adv_lvl;
    kick(vl, sv, pk, up, 1'b0, 0);
    for (int p = 0; p < veff * sv; p++) begin
      check("R6 busy", int'(busy), 1);
      check("R6 issue_pairs", int'(issue_pairs), 1);
      check("R14 no error while busy", int'(subvl_err), 0);
      check_pair(pk ? "R4" : (up ? "R5" : "R3"), p);
      if (poke && p == 2) begin
        cfg_vl = 7'd3; cfg_subvl = 3'd7; cfg_pack = ~pk; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    adv = 1'b0;
    check_finish();
  endtask

  // vertical-first walk with hold cycles before each step
  task automatic t_vert(int vl, int sv, bit pk, bit up, int hint);
    int grp, tot, pos, want;
    build(vl, sv, pk, up);
    tot = vl * sv;
    grp = (hint == 0) ? 1 : ((hint > vl) ? vl : hint) * sv;
    kick(vl, sv, pk, up, 1'b1, hint);
    pos = 0;
    while (pos < tot) begin
      want = (grp < tot - pos) ? grp : tot - pos;
      check("R8 busy", int'(busy), 1);
      check((want < grp) ? "R9 clipped issue" : (hint == vl ? "R10 issue" : "R8 issue"),
            int'(issue_pairs), want);
      check_pair("R7 before hold", pos);
      @(negedge clk);
      @(negedge clk);
      check_pair("R7 after hold", pos);
      adv = 1'b1;
      @(negedge clk);
      adv = 1'b0;
      pos += want;
    end
    check_finish();
  endtask

  task automatic t_bad_subvl(int sv);
    kick(4, sv, 1'b0, 1'b0, 1'b0, 0);
    check("R2 err pulse", int'(subvl_err), 1);
    check("R2 busy stays low", int'(busy), 0);
    check("R2 no done", int'(done), 0);
    @(negedge clk);
    check("R2 err one cycle", int'(subvl_err), 0);
    check("R2 still idle", int'(busy), 0);
  endtask

  task automatic t_empty();
    kick(0, 2, 1'b0, 1'b0, 1'b0, 0);
    check("R12 done pulse", int'(done), 1);
    check("R12 busy low", int'(busy), 0);
    check("R12 no issue", int'(issue_pairs), 0);
    @(negedge clk);
    check("R12 done one cycle", int'(done), 0);
    check("R12 still idle", int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_horiz(5, 3, 1'b0, 1'b0, 1'b0, 1'b0);   // R3
    t_horiz(5, 3, 1'b1, 1'b0, 1'b0, 1'b0);   // R4
    t_horiz(5, 3, 1'b0, 1'b1, 1'b0, 1'b0);   // R5
    t_horiz(4, 4, 1'b1, 1'b1, 1'b1, 1'b0);   // R4 R5 with adv held high (R6)
    t_horiz(8, 1, 1'b0, 1'b0, 1'b0, 1'b1);   // R14
    t_horiz(100, 1, 1'b0, 1'b0, 1'b0, 1'b0); // R13
    t_horiz(3, 2, 1'b0, 1'b0, 1'b0, 1'b0);   // R1 after walk
    t_bad_subvl(0);
    t_bad_subvl(5);
    t_bad_subvl(7);
    t_empty();
    t_vert(3, 2, 1'b1, 1'b0, 0);             // R7
    t_vert(10, 1, 1'b0, 1'b0, 4);            // R8 R9
    t_vert(7, 3, 1'b0, 1'b1, 2);             // R8 R9 with unpack
    t_vert(6, 2, 1'b1, 1'b1, 6);             // R10
    t_reset();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule